// File: doc/BRIEF.md
# Tilt Sensor SPI Command Interface

This block is the serial slave port of a single-axis tilt sensor. A host pulls chip select low, shifts in an 8-bit opcode, and the block replies on MISO with the register that opcode selects. Three opcodes return data: the 11-bit acceleration word, the 8-bit temperature word and an 8-bit status byte. Three more carry no data and only raise a one-cycle strobe, which the surrounding logic uses to change mode. These are the measure/exit-test command, the self-test entry command and the calibration reload request.

All SPI pins are oversampled in the system clock domain. The acceleration and temperature holding registers are reloaded from parallel inputs on a fixed period of system-clock cycles. Reloading is suspended for as long as chip select is low, so a frame always returns values that do not change under it. MISO has a separate output-enable, so several slaves can share one line.

Top module: `tilt_spi_slave`

## Requirements
- R1: A frame starts when chip select goes low and ends when it goes high. Raising chip select at any point clears the bit counter and the partly received command, so the next frame decodes from its first bit.
- R2: Opcodes and data are shifted most significant bit first. MOSI is sampled on rising SCK and MISO changes on falling SCK. The first data bit appears on the first falling SCK edge after the eighth command bit has been sampled.
- R3: Opcode 0x10 returns the 11-bit acceleration register. Opcode 0x08 returns the 8-bit temperature register; the 8 MOSI bits clocked in during that reply are ignored and leave the register unchanged. Opcode 0x0A returns an 8-bit status byte, with bit 0 = self-test-active input, bit 1 = parity-fault input, and bits 7..2 = 0.
- R4: Output-enable is low whenever chip select is high. While the command is being received, and after the last data bit until chip select rises, MISO is enabled and drives 0. Whenever output-enable is low, MISO is 0.
- R5: Any opcode outside {0x00, 0x08, 0x0A, 0x0B, 0x0E, 0x10} drops output-enable for the rest of the frame, and the MOSI bits that follow are ignored.
- R6: Opcodes 0x00 (measure), 0x0E (self-test entry) and 0x0B (reload) each raise their own strobe for exactly one clock once the eighth command bit is received. At most one strobe is high in any cycle, and the data-returning opcodes raise none.
- R7: While chip select is high, the acceleration and temperature registers reload from their parallel inputs once every REFRESH_CYC clocks. While chip select is low, both hold their value.
- R8: After reset the acceleration register holds 1024 (the zero-tilt code) and the temperature register holds 0.
- R9: Opcodes 0x00, 0x0E and 0x0B return no data: MISO stays enabled at 0 after the command until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock (idles low) |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Output-enable for the MISO pad driver |
| acc_data_i | input | 11 | Parallel acceleration sample from the converter |
| temp_data_i | input | 8 | Parallel temperature sample |
| selftest_act_i | input | 1 | Self-test currently active (status bit 0) |
| parity_err_i | input | 1 | Calibration parity fault (status bit 1) |
| meas_stb_o | output | 1 | One-cycle strobe for the measure/exit command |
| selftest_stb_o | output | 1 | One-cycle strobe for the self-test entry command |
| reload_stb_o | output | 1 | One-cycle strobe for the reload request |

## Verification
The assertions assume that SCK is at least four system clocks in each phase. They also assume that MOSI and chip select change well away from SCK edges, so that the synchronised copies of the three pins keep the order in which they changed at the pins. The stimulus drives every pin on the falling system-clock edge and uses an SCK half-period of eight system clocks. It changes MOSI only while SCK is low, and it moves chip select only while SCK is low. The freeze check on the data registers assumes that a reload can only follow a chip-select-high cycle of the synchronised pin, which the bench respects by never toggling chip select faster than the synchroniser depth.

// File: rtl/tilt_spi_pkg.sv
package tilt_spi_pkg;

    localparam int CMD_W  = 8;
    localparam int ACC_W  = 11;
    localparam int TEMP_W = 8;
    localparam int STAT_W = 8;

    localparam logic [CMD_W-1:0] OP_MEAS   = 8'h00;
    localparam logic [CMD_W-1:0] OP_TEMP   = 8'h08;
    localparam logic [CMD_W-1:0] OP_STATUS = 8'h0A;
    localparam logic [CMD_W-1:0] OP_RELOAD = 8'h0B;
    localparam logic [CMD_W-1:0] OP_SELFT  = 8'h0E;
    localparam logic [CMD_W-1:0] OP_ACCEL  = 8'h10;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_DATA,
        PH_TAIL,
        PH_DEAD
    } phase_e;

endpackage

// File: rtl/tilt_spi_sync.sv
module tilt_spi_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST;
                else        stg_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/tilt_spi_refresh.sv
module tilt_spi_refresh #(
    parameter int               ACC_W   = 11,
    parameter int               TEMP_W  = 8,
    parameter int               PERIOD  = 18750,
    parameter logic [ACC_W-1:0] ACC_RST = 11'd1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_idle_i,
    input  logic [ACC_W-1:0]  acc_in_i,
    input  logic [TEMP_W-1:0] temp_in_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic [TEMP_W-1:0] temp_o
);

    localparam int            CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [ACC_W-1:0]  acc;
        logic [TEMP_W-1:0] temp;
    } ref_t;

    ref_t d, q;

    always_comb begin
        d = q;
        if (q.cnt == LAST) begin
            d.cnt = '0;
            if (cs_idle_i) begin
                d.acc  = acc_in_i;
                d.temp = temp_in_i;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.acc  <= ACC_RST;
            q.temp <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o  = q.acc;
    assign temp_o = q.temp;

endmodule

// File: rtl/tilt_spi_frame.sv
module tilt_spi_frame
    import tilt_spi_pkg::*;
#(
    parameter int ACC_W  = 11,
    parameter int TEMP_W = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_s_i,
    input  logic              sck_s_i,
    input  logic              mosi_s_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              meas_stb_o,
    output logic              selftest_stb_o,
    output logic              reload_stb_o
);

    localparam int SH_A    = (ACC_W > TEMP_W) ? ACC_W : TEMP_W;
    localparam int SHIFT_W = (SH_A > STAT_W) ? SH_A : STAT_W;
    localparam int CNT_W   = $clog2(SHIFT_W + 1);
    localparam int NC_W    = $clog2(CMD_W);

    typedef struct packed {
        phase_e             ph;
        logic               sck_p;
        logic [NC_W-1:0]    ncmd;
        logic [CMD_W-1:0]   cmd;
        logic [SHIFT_W-1:0] sh;
        logic [CNT_W-1:0]   left;
        logic               miso;
        logic               oe;
        logic               s_meas;
        logic               s_selft;
        logic               s_reload;
    } frm_t;

    frm_t d, q;
    logic [CMD_W-1:0] cmd_nx;
    logic             sck_rise, sck_fall;

    assign sck_rise = sck_s_i & ~q.sck_p;
    assign sck_fall = ~sck_s_i & q.sck_p;
    assign cmd_nx   = {q.cmd[CMD_W-2:0], mosi_s_i};

    always_comb begin
        d          = q;
        d.sck_p    = sck_s_i;
        d.s_meas   = 1'b0;
        d.s_selft  = 1'b0;
        d.s_reload = 1'b0;
        if (csn_s_i) begin
            d.ph   = PH_IDLE;
            d.ncmd = '0;
            d.cmd  = '0;
            d.left = '0;
            d.miso = 1'b0;
            d.oe   = 1'b0;
        end else begin
            case (q.ph)
                PH_IDLE: begin
                    d.ph   = PH_CMD;
                    d.oe   = 1'b1;
                    d.miso = 1'b0;
                end
                PH_CMD: begin
                    if (sck_rise) begin
                        d.cmd  = cmd_nx;
                        d.ncmd = q.ncmd + 1'b1;
                        if (q.ncmd == NC_W'(CMD_W - 1)) begin
                            case (cmd_nx)
                                OP_ACCEL: begin
                                    d.sh   = SHIFT_W'(acc_i) << (SHIFT_W - ACC_W);
                                    d.left = CNT_W'(ACC_W);
                                    d.ph   = PH_DATA;
                                end
                                OP_TEMP: begin
                                    d.sh   = SHIFT_W'(temp_i) << (SHIFT_W - TEMP_W);
                                    d.left = CNT_W'(TEMP_W);
                                    d.ph   = PH_DATA;
                                end
                                OP_STATUS: begin
                                    d.sh   = SHIFT_W'(stat_i) << (SHIFT_W - STAT_W);
                                    d.left = CNT_W'(STAT_W);
                                    d.ph   = PH_DATA;
                                end
                                OP_MEAS: begin
                                    d.s_meas = 1'b1;
                                    d.ph     = PH_TAIL;
                                end
                                OP_SELFT: begin
                                    d.s_selft = 1'b1;
                                    d.ph      = PH_TAIL;
                                end
                                OP_RELOAD: begin
                                    d.s_reload = 1'b1;
                                    d.ph       = PH_TAIL;
                                end
                                default: begin
                                    d.ph = PH_DEAD;
                                    d.oe = 1'b0;
                                end
                            endcase
                        end
                    end
                end
                PH_DATA: begin
                    if (sck_fall) begin
                        if (q.left != '0) begin
                            d.miso = q.sh[SHIFT_W-1];
                            d.sh   = q.sh << 1;
                            d.left = q.left - 1'b1;
                        end else begin
                            d.miso = 1'b0;
                            d.ph   = PH_TAIL;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign miso_o         = q.miso;
    assign miso_oe_o      = q.oe;
    assign meas_stb_o     = q.s_meas;
    assign selftest_stb_o = q.s_selft;
    assign reload_stb_o   = q.s_reload;

endmodule

// File: rtl/tilt_spi_slave.sv
module tilt_spi_slave
    import tilt_spi_pkg::*;
#(
    parameter int ACC_W       = tilt_spi_pkg::ACC_W,
    parameter int TEMP_W      = tilt_spi_pkg::TEMP_W,
    parameter int SYNC_STAGES = 2,
    parameter int REFRESH_CYC = 18750
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic [ACC_W-1:0]  acc_data_i,
    input  logic [TEMP_W-1:0] temp_data_i,
    input  logic              selftest_act_i,
    input  logic              parity_err_i,
    output logic              meas_stb_o,
    output logic              selftest_stb_o,
    output logic              reload_stb_o
);

    localparam logic [ACC_W-1:0] ZERO_TILT = ACC_W'(1) << (ACC_W - 1);

    logic [2:0]        pins_s;
    logic              csn_sync, sck_sync, mosi_sync;
    logic [ACC_W-1:0]  acc_reg;
    logic [TEMP_W-1:0] temp_reg;
    logic [STAT_W-1:0] status;

    tilt_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({csn_i, sck_i, mosi_i}),
        .q_o   (pins_s)
    );

    assign csn_sync  = pins_s[2];
    assign sck_sync  = pins_s[1];
    assign mosi_sync = pins_s[0];
    assign status    = STAT_W'({parity_err_i, selftest_act_i});

    tilt_spi_refresh #(
        .ACC_W   (ACC_W),
        .TEMP_W  (TEMP_W),
        .PERIOD  (REFRESH_CYC),
        .ACC_RST (ZERO_TILT)
    ) u_refresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_idle_i (csn_sync),
        .acc_in_i  (acc_data_i),
        .temp_in_i (temp_data_i),
        .acc_o     (acc_reg),
        .temp_o    (temp_reg)
    );

    tilt_spi_frame #(.ACC_W(ACC_W), .TEMP_W(TEMP_W), .STAT_W(STAT_W)) u_frame (
        .clk            (clk),
        .rst_n          (rst_n),
        .csn_s_i        (csn_sync),
        .sck_s_i        (sck_sync),
        .mosi_s_i       (mosi_sync),
        .acc_i          (acc_reg),
        .temp_i         (temp_reg),
        .stat_i         (status),
        .miso_o         (miso_o),
        .miso_oe_o      (miso_oe_o),
        .meas_stb_o     (meas_stb_o),
        .selftest_stb_o (selftest_stb_o),
        .reload_stb_o   (reload_stb_o)
    );

endmodule

// File: rtl/tilt_spi_checker.sv
module tilt_spi_checker #(
    parameter int ACC_W  = 11,
    parameter int TEMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_i,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic              meas_stb_o,
    input logic              selftest_stb_o,
    input logic              reload_stb_o,
    input logic              csn_s,
    input logic [ACC_W-1:0]  acc_q,
    input logic [TEMP_W-1:0] temp_q
);

    // R4: a deselected slave releases the line after the synchroniser delay
    a_r4_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !miso_oe_o);

    // R4: the data pin is parked low whenever it is not enabled
    a_r4_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe_o |-> !miso_o);

    // R6: never two mode strobes in one cycle
    a_r6_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({meas_stb_o, selftest_stb_o, reload_stb_o}));

    // R6: each strobe lasts one cycle
    a_r6_meas_single: assert property (@(posedge clk) disable iff (!rst_n)
        meas_stb_o |=> !meas_stb_o);
    a_r6_selftest_single: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_stb_o |=> !selftest_stb_o);
    a_r6_reload_single: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb_o |=> !reload_stb_o);

    // R7: no reload of the data registers while selected
    a_r7_frozen_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !csn_s |=> ($stable(acc_q) && $stable(temp_q)));

endmodule

bind tilt_spi_slave tilt_spi_checker #(.ACC_W(ACC_W), .TEMP_W(TEMP_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .csn_i          (csn_i),
    .miso_o         (miso_o),
    .miso_oe_o      (miso_oe_o),
    .meas_stb_o     (meas_stb_o),
    .selftest_stb_o (selftest_stb_o),
    .reload_stb_o   (reload_stb_o),
    .csn_s          (csn_sync),
    .acc_q          (acc_reg),
    .temp_q         (temp_reg)
);

// File: tb/tilt_spi_slave_test.sv
module tilt_spi_slave_test;

    localparam int PERIOD = 40;
    localparam int HALF   = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sck, csn, mosi;
    logic        miso, miso_oe;
    logic [10:0] acc_in;
    logic [7:0]  temp_in;
    logic        st_act, par_err;
    logic        s_meas, s_selft, s_reload;

    int n_chk = 0;
    int n_fail = 0;
    int n_meas = 0, n_selft = 0, n_reload = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tilt_spi_slave #(.REFRESH_CYC(PERIOD)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sck_i          (sck),
        .csn_i          (csn),
        .mosi_i         (mosi),
        .miso_o         (miso),
        .miso_oe_o      (miso_oe),
        .acc_data_i     (acc_in),
        .temp_data_i    (temp_in),
        .selftest_act_i (st_act),
        .parity_err_i   (par_err),
        .meas_stb_o     (s_meas),
        .selftest_stb_o (s_selft),
        .reload_stb_o   (s_reload)
    );

    always @(posedge clk) begin
        if (s_meas)   n_meas++;
        if (s_selft)  n_selft++;
        if (s_reload) n_reload++;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle(input int n);
        csn = 1'b1; sck = 1'b0;
        wait_clk(n);
    endtask

    // Full frame; the expected reply bits come from a queue built from val.
    task automatic frame(input logic [7:0] op, input int nbits, input logic [15:0] val,
                         input bit valid, input string tag,
                         input int pre = 0, input logic [10:0] mid = '0);
        bit exp_q[$];
        csn = 1'b0;
        wait_clk(HALF);
        chk({"R4 enable at select ", tag}, {miso_oe, miso}, 2'b10);
        if (pre > 0) begin
            wait_clk(pre / 2);
            acc_in = mid;
            wait_clk(pre / 2);
        end
        for (int i = 0; i < 8; i++) begin
            mosi = op[7-i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            if (i < 7) chk({"R4 zero during command ", tag}, {miso_oe, miso}, 2'b10);
            sck = 1'b0;
        end
        for (int k = nbits - 1; k >= 0; k--) exp_q.push_back(val[k]);
        if (valid) begin
            for (int k = 0; k < nbits; k++) begin
                mosi = ~k[0];
                wait_clk(HALF);
                chk({"R2 R3 data bit ", tag}, {miso_oe, miso}, {1'b1, exp_q.pop_front()});
                sck = 1'b1;
                wait_clk(HALF);
                sck = 1'b0;
            end
            wait_clk(HALF);
            chk({"R4 R9 tail zero ", tag}, {miso_oe, miso}, 2'b10);
        end else begin
            for (int k = 0; k < 3; k++) begin
                mosi = k[0];
                wait_clk(HALF);
                chk({"R5 invalid silent ", tag}, {miso_oe, miso}, 2'b00);
                sck = 1'b1;
                wait_clk(HALF);
                sck = 1'b0;
            end
        end
        wait_clk(HALF);
        csn = 1'b1;
        wait_clk(HALF);
        chk({"R4 released ", tag}, {miso_oe, miso}, 2'b00);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int m0, s0, r0;
        rst_n = 1'b0; csn = 1'b1; sck = 1'b0; mosi = 1'b0;
        acc_in = 11'h2A5; temp_in = 8'h5C; st_act = 1'b0; par_err = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset idle", {miso_oe, miso}, 2'b00);
        chk("R6 reset strobes", {s_meas, s_selft, s_reload}, 3'b000);

        // R8: select before the first reload; zero-tilt code 1024
        frame(8'h10, 11, 16'd1024, 1, "r8_reset_accel");

        // R7: refresh while idle picks up the parallel input
        idle(3 * PERIOD);
        frame(8'h10, 11, 16'h2A5, 1, "r7_refresh_accel");

        // R3: temperature read twice; MOSI bits during the first are ignored
        frame(8'h08, 8, 16'h5C, 1, "r3_temp_first");
        idle(HALF);
        frame(8'h08, 8, 16'h5C, 1, "r3_temp_again");

        // R3: status byte layout
        st_act = 1'b1; par_err = 1'b0;
        idle(HALF);
        frame(8'h0A, 8, 16'h01, 1, "r3_status_selftest");
        st_act = 1'b0; par_err = 1'b1;
        idle(HALF);
        frame(8'h0A, 8, 16'h02, 1, "r3_status_parity");
        par_err = 1'b0;

        // R6 R9: mode commands
        m0 = n_meas; s0 = n_selft; r0 = n_reload;
        idle(HALF);
        frame(8'h00, 0, 16'h0, 1, "r9_meas");
        chk("R6 meas strobe count", 16'(n_meas - m0), 16'd1);
        idle(HALF);
        frame(8'h0E, 0, 16'h0, 1, "r9_selftest");
        chk("R6 selftest strobe count", 16'(n_selft - s0), 16'd1);
        idle(HALF);
        frame(8'h0B, 0, 16'h0, 1, "r9_reload");
        chk("R6 reload strobe count", 16'(n_reload - r0), 16'd1);
        chk("R6 no crossed strobes", 16'(n_meas - m0 + n_selft - s0 + n_reload - r0), 16'd3);

        // R5: opcodes outside the set
        idle(HALF);
        frame(8'h55, 0, 16'h0, 0, "r5_op55");
        idle(HALF);
        frame(8'h09, 0, 16'h0, 0, "r5_op09");
        idle(HALF);
        frame(8'h01, 0, 16'h0, 0, "r5_op01");

        // R1: abort mid-command, then a clean frame decodes from bit 0
        idle(HALF);
        csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < 4; i++) begin
            mosi = 1'b1;
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        idle(HALF);
        frame(8'h10, 11, 16'h2A5, 1, "r1_after_abort");

        // R7: freeze while selected, then refresh after release; full-scale code
        acc_in = 11'h7FF;
        idle(3 * PERIOD);
        frame(8'h10, 11, 16'h7FF, 1, "r7_frozen", 6 * PERIOD, 11'h001);
        idle(3 * PERIOD);
        frame(8'h10, 11, 16'h001, 1, "r7_after_release");

        m0 = n_meas + n_selft + n_reload;
        idle(HALF);
        frame(8'h10, 11, 16'h001, 1, "r6_data_no_strobe");
        chk("R6 data opcode raises no strobe", 16'(n_meas + n_selft + n_reload - m0), 16'd0);

        idle(HALF);
        finish_run();
    end

endmodule